// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block is the machine-mode register bank behind a small set of hardware debug triggers on a 32-bit core. It holds a trigger index register and, for every trigger, three words: a control word, a compare value and an extra-match word. It also holds a machine context value. Software first writes the index of a trigger, then reads or writes that trigger's words through a single CSR port. The port has an address, a write enable and write data, and its read data is combinational.

Every write is cleaned up before it is stored. The trigger type cannot be changed, fields the design does not support are stored as zero, a size code the design cannot honour falls back to "any size", and the context-select field is folded onto its two legal values. A read-only capability word lists the trigger types that exist. All stored words are driven out in parallel to the matching logic. Evaluating matches and acting on them are done outside this block.

Top module: `dbg_trig_bank`

## Requirements
- R1: A write to the index register (address 0) is accepted only when the write data, taken as an unsigned 32-bit value, is below NTRIG. Any other value leaves the index unchanged. Reading address 0 returns the index, zero-extended.
- R2: After any write to the control word (address 1), bits 31:28 hold type code 2 and bit 27 reads 0, whatever the write data held.
- R3: A control-word write keeps exactly the privilege enables at bits 6, 4 and 3 and the execute/store/load enables at bits 2, 1 and 0, together with the size bits of R4. Every other bit is stored as 0.
- R4: The size code is the 4-bit value {bits 22:21, bits 17:16} of the control word. Codes 0, 1, 2, 3 and 5 are stored as written. Any other code stores 0 in all four bits.
- R5: A write to the compare value (address 2) stores all 32 bits unchanged.
- R6: A write to the extra-match word (address 3) keeps the context value in bits 31:26. The context select in bits 25:23 is stored as 0 when the written value is 0 to 3 and as 4 when it is 4 to 7. Bits 22:0 are stored as 0.
- R7: The capability word (address 4) always reads 0x00000044, which marks types 2 and 6. Writes to it change nothing.
- R8: After reset the index is 0. Every control word reads 0x20000000, and every compare value, extra-match word and the context register read 0.
- R9: Reads and writes at addresses 1 to 3 act only on the trigger currently selected. Read data is valid in the same cycle as the address. A write becomes visible on the read port and on the trigger outputs from the clock edge that captures it.
- R10: Address 5 holds a 6-bit machine context value, written from bits 5:0 and read back zero-extended. Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 3 | Register address: 0 index, 1 control, 2 compare, 3 extra-match, 4 capability, 5 context |
| csr_we | input | 1 | Write enable for the addressed register |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data of the addressed register |
| trig_ctrl_o | output | 32*NTRIG | Stored control words, trigger i in slice i |
| trig_cmp_o | output | 32*NTRIG | Stored compare values |
| trig_extra_o | output | 32*NTRIG | Stored extra-match words |
| mctx_o | output | 6 | Stored machine context value |

## Verification
Read data is due in the same cycle its address is presented. A write lands at the next rising edge, so it is seen on the read port and on the parallel outputs one edge after the write enable is sampled. The bench drives each step just after a falling edge and compares the read port and every output against its own model a moment later, before the next rising edge. The model updates only after that edge, so each comparison sees exactly the writes that have already been clocked in.

// File: rtl/dbg_trig_bank.sv
`timescale 1ns/1ps
module dbg_trig_bank #(
  parameter int NTRIG = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            csr_addr,
  input  logic                  csr_we,
  input  logic [31:0]           csr_wdata,
  output logic [31:0]           csr_rdata,
  output logic [32*NTRIG-1:0]   trig_ctrl_o,
  output logic [32*NTRIG-1:0]   trig_cmp_o,
  output logic [32*NTRIG-1:0]   trig_extra_o,
  output logic [5:0]            mctx_o
);
  localparam int          SELW    = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam logic [3:0]  TYPE_AM = 4'd2;
  localparam logic [31:0] CTRL_RST = {TYPE_AM, 28'd0};
  localparam logic [31:0] CAPS    = 32'h0000_0044;

  logic [SELW-1:0] sel_q;
  logic [31:0]     ctrl_q  [NTRIG];
  logic [31:0]     cmp_q   [NTRIG];
  logic [31:0]     extra_q [NTRIG];
  logic [5:0]      mctx_q;

  wire we_sel = csr_we && (csr_addr == 3'd0);
  wire we_c1  = csr_we && (csr_addr == 3'd1);
  wire we_c2  = csr_we && (csr_addr == 3'd2);
  wire we_c3  = csr_we && (csr_addr == 3'd3);
  wire we_ctx = csr_we && (csr_addr == 3'd5);

  wire [3:0] size_code = {csr_wdata[22:21], csr_wdata[17:16]};
  wire       size_ok   = (size_code <= 4'd3) || (size_code == 4'd5);

  logic [31:0] ctrl_new;
  always_comb begin
    ctrl_new        = CTRL_RST;
    ctrl_new[6]     = csr_wdata[6];
    ctrl_new[4:0]   = csr_wdata[4:0];
    if (size_ok) begin
      ctrl_new[22:21] = csr_wdata[22:21];
      ctrl_new[17:16] = csr_wdata[17:16];
    end
  end

  wire [31:0] extra_new = {csr_wdata[31:26], csr_wdata[25], 25'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mctx_q <= '0;
    end else begin
      if (we_sel && (csr_wdata < 32'(NTRIG))) sel_q <= csr_wdata[SELW-1:0];
      if (we_ctx) mctx_q <= csr_wdata[5:0];
    end
  end

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    wire hit = (32'(sel_q) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[i]  <= CTRL_RST;
        cmp_q[i]   <= '0;
        extra_q[i] <= '0;
      end else if (hit) begin
        if (we_c1) ctrl_q[i]  <= ctrl_new;
        if (we_c2) cmp_q[i]   <= csr_wdata;
        if (we_c3) extra_q[i] <= extra_new;
      end
    end
    assign trig_ctrl_o[32*i +: 32]  = ctrl_q[i];
    assign trig_cmp_o[32*i +: 32]   = cmp_q[i];
    assign trig_extra_o[32*i +: 32] = extra_q[i];
  end

  always_comb begin
    case (csr_addr)
      3'd0:    csr_rdata = 32'(sel_q);
      3'd1:    csr_rdata = ctrl_q[sel_q];
      3'd2:    csr_rdata = cmp_q[sel_q];
      3'd3:    csr_rdata = extra_q[sel_q];
      3'd4:    csr_rdata = CAPS;
      3'd5:    csr_rdata = {26'd0, mctx_q};
      default: csr_rdata = '0;
    endcase
  end

  assign mctx_o = mctx_q;
endmodule

// File: rtl/dbg_trig_bank_chk.sv
`timescale 1ns/1ps
module dbg_trig_bank_chk #(
  parameter int NTRIG = 2,
  parameter int SELW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          csr_addr,
  input logic                csr_we,
  input logic [31:0]         csr_wdata,
  input logic [31:0]         csr_rdata,
  input logic [32*NTRIG-1:0] ctrl,
  input logic [32*NTRIG-1:0] cmp,
  input logic [32*NTRIG-1:0] extra,
  input logic [SELW-1:0]     sel
);
  logic [SELW-1:0] psel;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psel <= '0; else psel <= sel;

  wire [31:0] cmp_prev_sel = cmp[32*int'(psel) +: 32];

  a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd0 && csr_wdata >= 32'(NTRIG)) |=> $stable(sel));

  a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel) < 32'(NTRIG));

  a_r5_cmp_store: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 3'd2) |=> cmp_prev_sel == $past(csr_wdata));

  a_r7_caps: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 3'd4) |-> csr_rdata == 32'h0000_0044);

  for (genvar i = 0; i < NTRIG; i++) begin : g_chk
    wire [31:0] c = ctrl[32*i +: 32];
    wire [31:0] e = extra[32*i +: 32];
    wire [3:0]  sc = {c[22:21], c[17:16]};

    a_r2_type_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      c[31:27] == 5'b00100);

    a_r3_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (c[26:23] == 4'd0) && (c[20:18] == 3'd0) && (c[15:7] == 9'd0) && !c[5]);

    a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (sc <= 4'd3) || (sc == 4'd5));

    a_r6_extra_fold: assert property (@(posedge clk) disable iff (!rst_n)
      e[24:0] == 25'd0);
  end
endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(.NTRIG(NTRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ctrl(trig_ctrl_o),
  .cmp(trig_cmp_o), .extra(trig_extra_o), .sel(sel_q)
);

// File: tb/dbg_trig_bank_tb.sv
`timescale 1ns/1ps
module dbg_trig_bank_tb;
  localparam int NT = 2;

  logic              clk = 0;
  logic              rst_n = 0;
  logic [2:0]        csr_addr = 0;
  logic              csr_we = 0;
  logic [31:0]       csr_wdata = 0;
  logic [31:0]       csr_rdata;
  logic [32*NT-1:0]  trig_ctrl_o, trig_cmp_o, trig_extra_o;
  logic [5:0]        mctx_o;

  dbg_trig_bank #(.NTRIG(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl_o(trig_ctrl_o),
    .trig_cmp_o(trig_cmp_o), .trig_extra_o(trig_extra_o), .mctx_o(mctx_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int unsigned m_sel;
  logic [31:0] m_ctrl [NT];
  logic [31:0] m_cmp  [NT];
  logic [31:0] m_extra[NT];
  logic [5:0]  m_ctx;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_sel;
      3'd1: return m_ctrl[m_sel];
      3'd2: return m_cmp[m_sel];
      3'd3: return m_extra[m_sel];
      3'd4: return 32'h44;
      3'd5: return {26'd0, m_ctx};
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] legal_ctrl(logic [31:0] d);
    logic [31:0] r;
    int code;
    r = 32'h2000_0000 | (d & 32'h0000_005F);
    code = {d[22:21], d[17:16]};
    if (code == 0 || code == 1 || code == 2 || code == 3 || code == 5)
      r = r | (d & 32'h0063_0000);
    return r;
  endfunction

  function automatic logic [31:0] legal_extra(logic [31:0] d);
    int s;
    s = d[25:23];
    return (d & 32'hFC00_0000) | ((s >= 4) ? 32'h0200_0000 : 32'h0);
  endfunction

  task automatic m_reset();
    m_sel = 0; m_ctx = 0;
    for (int i = 0; i < NT; i++) begin
      m_ctrl[i] = 32'h2000_0000; m_cmp[i] = 0; m_extra[i] = 0;
    end
  endtask

  task automatic cyc(string tag, logic [2:0] a, logic w, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_we = w; csr_wdata = d;
    #1;
    chk(tag, "rdata", csr_rdata, m_read(a));
    for (int i = 0; i < NT; i++) begin
      chk(tag, "ctrl_o",  trig_ctrl_o[32*i +: 32],  m_ctrl[i]);
      chk(tag, "cmp_o",   trig_cmp_o[32*i +: 32],   m_cmp[i]);
      chk(tag, "extra_o", trig_extra_o[32*i +: 32], m_extra[i]);
    end
    chk(tag, "mctx_o", {26'd0, mctx_o}, {26'd0, m_ctx});
    @(posedge clk);
    if (w) begin
      case (a)
        3'd0: if (d < NT) m_sel = d;
        3'd1: m_ctrl[m_sel]  = legal_ctrl(d);
        3'd2: m_cmp[m_sel]   = d;
        3'd3: m_extra[m_sel] = legal_extra(d);
        3'd5: m_ctx = d[5:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(string tag, logic [2:0] a); cyc(tag, a, 1'b0, 0); endtask
  task automatic wr(string tag, logic [2:0] a, logic [31:0] d); cyc(tag, a, 1'b1, d); rd(tag, a); endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) rd("R8", a[2:0]);
    wr("R1", 0, 1);
    for (int a = 0; a < 6; a++) rd("R8", a[2:0]);
    wr("R1", 0, 0);
    // control word legalization
    wr("R2", 1, 32'hFFFF_FFFF);
    wr("R2", 1, 32'h6800_0008);
    wr("R3", 1, 32'h0001_0047);
    wr("R3", 1, 32'h1FFC_FFA0);
    wr("R4", 1, 32'h0021_0001);
    wr("R4", 1, 32'h0020_0002);
    wr("R4", 1, 32'h0003_0004);
    wr("R4", 1, 32'h0040_0010);
    wr("R4", 1, 32'h0060_0001);
    // select range
    wr("R1", 0, 1);
    wr("R1", 0, 2);
    wr("R1", 0, 32'hFFFF_FFFF);
    wr("R1", 0, 32'h8000_0000);
    // per-trigger isolation
    wr("R5", 2, 32'hDEAD_BEEF);
    wr("R9", 1, 32'h0000_0041);
    wr("R6", 3, 32'hFFFF_FFFF);
    wr("R1", 0, 0);
    rd("R9", 1); rd("R9", 2); rd("R9", 3);
    wr("R5", 2, 32'h1234_5678);
    // extra-match folding
    wr("R6", 3, 32'h0180_0000);
    wr("R6", 3, 32'h0200_0000);
    wr("R6", 3, 32'hA8FF_FFFF);
    wr("R6", 3, 32'h0380_0000);
    // capability, context, unmapped
    wr("R7", 4, 32'hFFFF_FFFF);
    wr("R10", 5, 32'hFFFF_FFC5);
    wr("R10", 6, 32'hFFFF_FFFF);
    wr("R10", 7, 32'h1234_5678);
    rd("R10", 5);
    for (int a = 0; a < 8; a++) rd("R9", a[2:0]);
    // reset again mid-run
    @(negedge clk); rst_n = 0; m_reset();
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 6; a++) rd("R8", a[2:0]);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule